// File: doc/BRIEF.md
# Add-Instruction Micro-Op Cracker

This block sits behind an instruction decoder. It takes one decoded add instruction at a time, whose operands may be in registers or in memory, and turns it into a short, ordered stream of simple micro-operations. In that stream only loads and stores touch memory. The arithmetic micro-op always works on registers. When a memory operand has to be combined, the block sends it through a hidden temporary register.

The input and the output each use a valid/ready handshake. The block holds one instruction while its micro-ops drain. It accepts the next instruction in the same cycle that the last micro-op of the current one is taken, so register-only adds can flow at one per cycle. Each micro-op carries:
- its kind;
- up to three register specifiers, which can name the temporary;
- the memory address tag, on loads and stores only;
- the sequence tag of its instruction;
- flags that mark the first and the last micro-op of the instruction.

Top module: `uop_cracker`

## Requirements
- R1: Operand form 0 (register destination, register source) yields exactly one micro-op of kind 1 (ADD), with dst = destination, srcA = destination and srcB = source. Both first and last are set.
- R2: Operand form 1 (register destination, memory source) yields two micro-ops.
  - The first is kind 0 (LOAD), with dst = TMP and the instruction's address tag.
  - The second is an ADD with dst = destination, srcA = destination and srcB = TMP, and it carries last.
  - TMP is the specifier value ARCH_REGS, which is 8 by default.
- R3: Operand form 2 (memory destination, register source) yields three micro-ops in this order:
  - a LOAD with dst = TMP and the address tag;
  - an ADD with dst = TMP, srcA = TMP and srcB = source;
  - a kind 2 (STORE) with srcA = TMP and the same address tag, which carries last.
- R4: An ADD micro-op never carries a memory operand: its address field is zero. Every LOAD and STORE carries the address tag of its instruction.
- R5: Operand form 3 is unsupported. It yields a single micro-op of kind 3 (ILLEGAL) with first and last set, and with all register and address fields zero.
- R6: While an instruction's micro-ops are outstanding, input ready is low. The one exception is the cycle in which its last micro-op is accepted; in that cycle ready is high and a new instruction may be taken. With no instruction held, input ready is high.
- R7: While output valid is high and output ready is low, all output fields hold their values in the next cycle. The block moves to the next micro-op only on an accepted transfer.
- R8: The first flag is set only on the first micro-op of an instruction, and the last flag only on its final micro-op. Every micro-op carries the sequence tag of its instruction.
- R9: A synchronous reset drops output valid, raises input ready and discards any partly emitted instruction. The next instruction accepted starts at its first micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Instruction can be taken this cycle |
| inForm | input | 2 | Operand form: 0 reg/reg, 1 reg dst + mem src, 2 mem dst + reg src, 3 unsupported |
| inDst | input | $clog2(ARCH_REGS) | Destination register index |
| inSrc | input | $clog2(ARCH_REGS) | Source register index |
| inAddr | input | TAG_W | Memory address tag |
| inSeq | input | SEQ_W | Instruction sequence tag |
| outValid | output | 1 | Micro-op offered |
| outReady | input | 1 | Downstream takes the micro-op |
| outKind | output | 2 | 0 LOAD, 1 ADD, 2 STORE, 3 ILLEGAL |
| outDst | output | $clog2(ARCH_REGS+1) | Written register specifier (TMP = ARCH_REGS) |
| outSrcA | output | $clog2(ARCH_REGS+1) | First read register specifier |
| outSrcB | output | $clog2(ARCH_REGS+1) | Second read register specifier |
| outAddr | output | TAG_W | Address tag (zero unless LOAD or STORE) |
| outSeq | output | SEQ_W | Sequence tag of the owning instruction |
| outFirst | output | 1 | First micro-op of the instruction |
| outLast | output | 1 | Final micro-op of the instruction |

## Verification
The assertions check several properties on every cycle:
- the output fields hold still during backpressure;
- ADD never carries an address;
- loads target TMP and stores read TMP;
- input ready stays low while micro-ops are still pending;
- illegal micro-ops stand alone;
- only the last micro-op may be followed by a new first one.

Only the bench's sweep can show the rest: that each operand form produces exactly the right number of micro-ops, with the right register indices, address and sequence tags, in the right order and under irregular stalls, and that a reset in the middle of an instruction discards what is left of it.

// File: rtl/uop_cracker_pkg.sv
package uop_cracker_pkg;

  localparam int STEP_W = 2;

  typedef enum logic [1:0] {
    FORM_RR  = 2'd0,
    FORM_RM  = 2'd1,
    FORM_MR  = 2'd2,
    FORM_BAD = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    UOP_LOAD    = 2'd0,
    UOP_ADD     = 2'd1,
    UOP_STORE   = 2'd2,
    UOP_ILLEGAL = 2'd3
  } kind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic              capture;
    logic              last;
    logic [STEP_W-1:0] step;
  } strobe_t;

  function automatic logic [STEP_W-1:0] uopCount(input logic [1:0] form);
    case (form)
      FORM_RM: uopCount = STEP_W'(2);
      FORM_MR: uopCount = STEP_W'(3);
      default: uopCount = STEP_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/uop_cracker_ctrl.sv
module uop_cracker_ctrl
  import uop_cracker_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] inForm,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output strobe_t    strobes
);

  logic              busy;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] count;
  logic              isLast;
  logic              fire;
  logic              lastFire;
  logic              accept;

  always_comb begin
    isLast   = (step == count - 1'b1);
    fire     = busy && outReady;
    lastFire = fire && isLast;
    inReady  = !busy || lastFire;
    accept   = inValid && inReady;
    outValid = busy;
    strobes  = '{capture: accept, last: isLast, step: step};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      step  <= '0;
      count <= STEP_W'(1);
    end else if (accept) begin
      busy  <= 1'b1;
      step  <= '0;
      count <= uopCount(inForm);
    end else if (lastFire) begin
      busy <= 1'b0;
      step <= '0;
    end else if (fire) begin
      step <= step + 1'b1;
    end
  end

endmodule

// File: rtl/uop_cracker_dp.sv
module uop_cracker_dp
  import uop_cracker_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int TAG_W     = 8,
  parameter int SEQ_W     = 4,
  localparam int ARCH_W   = $clog2(ARCH_REGS),
  localparam int SPEC_W   = $clog2(ARCH_REGS + 1)
) (
  input  logic              clk,
  input  strobe_t           strobes,
  input  logic [1:0]        inForm,
  input  logic [ARCH_W-1:0] inDst,
  input  logic [ARCH_W-1:0] inSrc,
  input  logic [TAG_W-1:0]  inAddr,
  input  logic [SEQ_W-1:0]  inSeq,
  output logic [1:0]        outKind,
  output logic [SPEC_W-1:0] outDst,
  output logic [SPEC_W-1:0] outSrcA,
  output logic [SPEC_W-1:0] outSrcB,
  output logic [TAG_W-1:0]  outAddr,
  output logic [SEQ_W-1:0]  outSeq,
  output logic              outFirst,
  output logic              outLast
);

  localparam logic [SPEC_W-1:0] TMP = SPEC_W'(ARCH_REGS);

  logic [1:0]        formQ;
  logic [ARCH_W-1:0] dstQ;
  logic [ARCH_W-1:0] srcQ;
  logic [TAG_W-1:0]  addrQ;
  logic [SEQ_W-1:0]  seqQ;
  logic [SPEC_W-1:0] dstSpec;
  logic [SPEC_W-1:0] srcSpec;
  kind_e             kind;

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      formQ <= inForm;
      dstQ  <= inDst;
      srcQ  <= inSrc;
      addrQ <= inAddr;
      seqQ  <= inSeq;
    end
  end

  always_comb begin
    dstSpec  = SPEC_W'(dstQ);
    srcSpec  = SPEC_W'(srcQ);
    kind     = UOP_ILLEGAL;
    outDst   = '0;
    outSrcA  = '0;
    outSrcB  = '0;
    outAddr  = '0;
    outSeq   = seqQ;
    outFirst = (strobes.step == '0);
    outLast  = strobes.last;
    case (formQ)
      FORM_RR: begin
        kind    = UOP_ADD;
        outDst  = dstSpec;
        outSrcA = dstSpec;
        outSrcB = srcSpec;
      end
      FORM_RM: begin
        if (strobes.step == '0) begin
          kind    = UOP_LOAD;
          outDst  = TMP;
          outAddr = addrQ;
        end else begin
          kind    = UOP_ADD;
          outDst  = dstSpec;
          outSrcA = dstSpec;
          outSrcB = TMP;
        end
      end
      FORM_MR: begin
        if (strobes.step == '0) begin
          kind    = UOP_LOAD;
          outDst  = TMP;
          outAddr = addrQ;
        end else if (strobes.step == STEP_W'(1)) begin
          kind    = UOP_ADD;
          outDst  = TMP;
          outSrcA = TMP;
          outSrcB = srcSpec;
        end else begin
          kind    = UOP_STORE;
          outSrcA = TMP;
          outAddr = addrQ;
        end
      end
      default: kind = UOP_ILLEGAL;
    endcase
    outKind = kind;
  end

endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
  import uop_cracker_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int TAG_W     = 8,
  parameter int SEQ_W     = 4,
  localparam int ARCH_W   = $clog2(ARCH_REGS),
  localparam int SPEC_W   = $clog2(ARCH_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inForm,
  input  logic [ARCH_W-1:0] inDst,
  input  logic [ARCH_W-1:0] inSrc,
  input  logic [TAG_W-1:0]  inAddr,
  input  logic [SEQ_W-1:0]  inSeq,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outKind,
  output logic [SPEC_W-1:0] outDst,
  output logic [SPEC_W-1:0] outSrcA,
  output logic [SPEC_W-1:0] outSrcB,
  output logic [TAG_W-1:0]  outAddr,
  output logic [SEQ_W-1:0]  outSeq,
  output logic              outFirst,
  output logic              outLast
);

  strobe_t strobes;

  uop_cracker_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inForm  (inForm),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobes (strobes)
  );

  uop_cracker_dp #(
    .ARCH_REGS(ARCH_REGS),
    .TAG_W    (TAG_W),
    .SEQ_W    (SEQ_W)
  ) dp_i (
    .clk     (clk),
    .strobes (strobes),
    .inForm  (inForm),
    .inDst   (inDst),
    .inSrc   (inSrc),
    .inAddr  (inAddr),
    .inSeq   (inSeq),
    .outKind (outKind),
    .outDst  (outDst),
    .outSrcA (outSrcA),
    .outSrcB (outSrcB),
    .outAddr (outAddr),
    .outSeq  (outSeq),
    .outFirst(outFirst),
    .outLast (outLast)
  );

endmodule

// File: rtl/uop_cracker_chk.sv
module uop_cracker_chk #(
  parameter int ARCH_REGS = 8,
  parameter int TAG_W     = 8,
  parameter int SEQ_W     = 4,
  localparam int SPEC_W   = $clog2(ARCH_REGS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [1:0]        outKind,
  input logic [SPEC_W-1:0] outDst,
  input logic [SPEC_W-1:0] outSrcA,
  input logic [SPEC_W-1:0] outSrcB,
  input logic [TAG_W-1:0]  outAddr,
  input logic [SEQ_W-1:0]  outSeq,
  input logic              outFirst,
  input logic              outLast
);

  localparam logic [SPEC_W-1:0] TMP = SPEC_W'(ARCH_REGS);

  assert_single_add_R1: assert property (@(posedge clk) disable iff (rst)
    outValid && outKind == 2'd1 && outFirst |-> outLast && outDst < TMP);

  assert_load_tmp_R2: assert property (@(posedge clk) disable iff (rst)
    outValid && outKind == 2'd0 |-> outDst == TMP && outFirst && !outLast);

  assert_store_tmp_R3: assert property (@(posedge clk) disable iff (rst)
    outValid && outKind == 2'd2 |-> outSrcA == TMP && outLast && !outFirst);

  assert_add_nomem_R4: assert property (@(posedge clk) disable iff (rst)
    outValid && outKind == 2'd1 |-> outAddr == '0);

  assert_illegal_alone_R5: assert property (@(posedge clk) disable iff (rst)
    outValid && outKind == 2'd3 |-> outFirst && outLast);

  assert_ready_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    outValid && !(outReady && outLast) |-> !inReady);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable({outKind, outDst, outSrcA,
      outSrcB, outAddr, outSeq, outFirst, outLast}));

  assert_mid_not_first_R8: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && !outLast |=> outValid && !outFirst);

  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> !outValid && inReady);

endmodule

bind uop_cracker uop_cracker_chk #(
  .ARCH_REGS(ARCH_REGS),
  .TAG_W    (TAG_W),
  .SEQ_W    (SEQ_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outKind (outKind),
  .outDst  (outDst),
  .outSrcA (outSrcA),
  .outSrcB (outSrcB),
  .outAddr (outAddr),
  .outSeq  (outSeq),
  .outFirst(outFirst),
  .outLast (outLast)
);

// File: tb/uop_cracker_tb_top.sv
`timescale 1ns/1ps
module uop_cracker_tb_top;

  localparam int TMP = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       inValid;
  logic       inReady;
  logic [1:0] inForm;
  logic [2:0] inDst;
  logic [2:0] inSrc;
  logic [7:0] inAddr;
  logic [3:0] inSeq;
  logic       outValid;
  logic       outReady;
  logic [1:0] outKind;
  logic [3:0] outDst;
  logic [3:0] outSrcA;
  logic [3:0] outSrcB;
  logic [7:0] outAddr;
  logic [3:0] outSeq;
  logic       outFirst;
  logic       outLast;

  always #10 clk = ~clk;

  uop_cracker dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inForm(inForm), .inDst(inDst), .inSrc(inSrc), .inAddr(inAddr),
    .inSeq(inSeq), .outValid(outValid), .outReady(outReady),
    .outKind(outKind), .outDst(outDst), .outSrcA(outSrcA),
    .outSrcB(outSrcB), .outAddr(outAddr), .outSeq(outSeq),
    .outFirst(outFirst), .outLast(outLast)
  );

  // fields: kind, dst, srcA, srcB, addr, seq, first, last (28 bits)
  typedef struct packed {
    logic [1:0]  form;
    logic [27:0] bits;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   fails  = 0;

  function automatic logic [27:0] pack(input logic [1:0] k, input logic [3:0] d,
      input logic [3:0] a, input logic [3:0] b, input logic [7:0] ad,
      input logic [3:0] sq, input logic f, input logic l);
    return {k, d, a, b, ad, sq, f, l};
  endfunction

  function automatic logic [27:0] curBits();
    return pack(outKind, outDst, outSrcA, outSrcB, outAddr, outSeq, outFirst, outLast);
  endfunction

  function automatic string reqOf(input logic [1:0] form);
    case (form)
      2'd0: return "R1/R4/R8";
      2'd1: return "R2/R4/R8";
      2'd2: return "R3/R4/R8";
      default: return "R5/R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected micro-ops of one instruction, from the requirements
  task automatic pushExpected(input logic [1:0] f, input logic [3:0] d,
      input logic [3:0] s, input logic [7:0] ad, input logic [3:0] sq);
    case (f)
      2'd0: expQ.push_back('{f, pack(2'd1, d, d, s, 8'd0, sq, 1'b1, 1'b1)});
      2'd1: begin
        expQ.push_back('{f, pack(2'd0, 4'(TMP), 4'd0, 4'd0, ad, sq, 1'b1, 1'b0)});
        expQ.push_back('{f, pack(2'd1, d, d, 4'(TMP), 8'd0, sq, 1'b0, 1'b1)});
      end
      2'd2: begin
        expQ.push_back('{f, pack(2'd0, 4'(TMP), 4'd0, 4'd0, ad, sq, 1'b1, 1'b0)});
        expQ.push_back('{f, pack(2'd1, 4'(TMP), 4'(TMP), s, 8'd0, sq, 1'b0, 1'b0)});
        expQ.push_back('{f, pack(2'd2, 4'd0, 4'(TMP), 4'd0, ad, sq, 1'b0, 1'b1)});
      end
      default: expQ.push_back('{f, pack(2'd3, 4'd0, 4'd0, 4'd0, 8'd0, sq, 1'b1, 1'b1)});
    endcase
  endtask

  initial begin
    int          idx = 0;
    int          cyc = 0;
    logic        holdPrev = 1'b0;
    logic [27:0] snap = '0;
    exp_t        head;

    rst = 1'b1; inValid = 1'b0; outReady = 1'b0;
    inForm = '0; inDst = '0; inSrc = '0; inAddr = '0; inSeq = '0;
    repeat (3) @(negedge clk);
    // R9: idle after reset
    check("R9 reset outValid", 32'(outValid), 32'd0);
    check("R9 reset inReady", 32'(inReady), 32'd1);
    rst = 1'b0;

    // sweep every form x dst x src under varied backpressure
    while ((idx < 256 || expQ.size() != 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      inValid  = (idx < 256);
      inForm   = 2'(idx >> 6);
      inDst    = 3'(idx >> 3);
      inSrc    = 3'(idx);
      inAddr   = 8'((idx * 37 + 5) & 255);
      inSeq    = 4'(idx);
      outReady = ((idx % 3) == 0) ? 1'b1 : ((cyc % 5 != 2) && (cyc % 7 != 3));
      #1;
      if (holdPrev) begin
        check("R7 valid held", 32'(outValid), 32'd1);
        check("R7 fields held", 32'(curBits()), 32'(snap));
      end
      if (outValid) begin
        if (expQ.size() == 0) begin
          check("R8 unexpected micro-op", 32'(curBits()), 32'hFFFF_FFFF);
        end else begin
          head = expQ[0];
          check(reqOf(head.form), 32'(curBits()), 32'(head.bits));
          check("R6 input ready", 32'(inReady), 32'(outReady && head.bits[0]));
          if (outReady) void'(expQ.pop_front());
        end
      end else begin
        check("R6 idle ready", 32'(inReady), 32'd1);
      end
      holdPrev = outValid && !outReady;
      snap     = curBits();
      if (inValid && inReady) begin
        pushExpected(inForm, 4'(inDst), 4'(inSrc), inAddr, inSeq);
        idx++;
      end
    end
    if (cyc >= 20000) check("watchdog", 32'(cyc), 32'd0);

    // R9: reset in the middle of a three micro-op instruction
    @(negedge clk);
    inValid = 1'b1; inForm = 2'd2; inDst = 3'd1; inSrc = 3'd2; inAddr = 8'h5A; inSeq = 4'd9;
    outReady = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    #1;
    check("R3 first LOAD", 32'(curBits()), 32'(pack(2'd0, 4'(TMP), 4'd0, 4'd0, 8'h5A, 4'd9, 1'b1, 1'b0)));
    outReady = 1'b1;
    @(negedge clk);
    rst = 1'b1; outReady = 1'b0;
    @(negedge clk);
    #1;
    check("R9 mid reset outValid", 32'(outValid), 32'd0);
    check("R9 mid reset inReady", 32'(inReady), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    inValid = 1'b1; inForm = 2'd1; inDst = 3'd3; inSrc = 3'd4; inAddr = 8'hC3; inSeq = 4'd2;
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    #1;
    check("R9 restart first", 32'(curBits()), 32'(pack(2'd0, 4'(TMP), 4'd0, 4'd0, 8'hC3, 4'd2, 1'b1, 1'b0)));
    @(negedge clk);
    #1;
    check("R2 restart ADD", 32'(curBits()), 32'(pack(2'd1, 4'd3, 4'd3, 4'(TMP), 8'd0, 4'd2, 1'b0, 1'b1)));
    @(negedge clk);
    #1;
    check("R6 drained", 32'({outValid, inReady}), 32'b01);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule